// File: doc/BRIEF.md
# Input-Stationary 1-D Convolution Engine

This block computes a valid-mode 1-D convolution with the input activation held fixed. For each input position `h`, taken in ascending order, the engine reads the activation once and keeps it in a register. It then walks every filter tap `r`. For each tap it multiplies the held activation by the tap weight and adds the product into output `h - r`, using a read-modify-write of the output buffer.

Some `(h, r)` pairs land outside the valid output range `0 <= h - r < E`, where `E = H - R + 1`. For those pairs the engine performs no weight read, no output access and no multiply. The first time an output position is touched (tap `r = 0`), the engine treats its old content as zero. The output buffer therefore needs no clearing before a run.

The host programs the input length and the filter length, pulses `start` and waits for a one-cycle `done`. All three buffers are external synchronous-read memories: data arrives the cycle after the read enable. Four counters report how many input reads, weight reads, output reads and output writes the run made.

Top module: `conv_is_engine`

## Requirements
- R1: After a run with length H and filter length R (1 <= R <= H <= MAX_H), output buffer entry e holds the sum over r of I[e+r]*W[r] for every e in 0..H-R. Operands are signed 8-bit, and sums wrap at 24 bits in two's complement. Writes occur in loop order: h ascending, and r ascending within each h.
- R2: No output read or write addresses an entry at or above E = H-R+1. Entries from E upward keep their prior contents.
- R3: Each input activation is read exactly once per run, at addresses 0..H-1 in ascending order. The input read count equals H.
- R4: The weight read count, the output read count and the output write count each equal E*R after a run. A weight read is always accompanied by an output read in the same cycle.
- R5: Each output write goes to the address read in the previous cycle. No output read is issued in a write cycle.
- R6: The contribution with r = 0 ignores whatever the output buffer held, so stale buffer contents never reach a result.
- R7: `done` is high for exactly one cycle, the cycle after the last output write. The counters then hold their values until the next start.
- R8: A `start` pulse while a run is in progress has no effect on the results or the counters.
- R9: After reset, all read and write enables and `done` are low and all counters are zero. Accepting `start` clears the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| cfg_h | input | IW | Input length H |
| cfg_r | input | IW | Filter length R |
| in_rd_en | output | 1 | Input buffer read enable |
| in_rd_addr | output | AW | Input buffer address |
| in_rd_data | input | DW | Input buffer data, one cycle after enable |
| w_rd_en | output | 1 | Weight buffer read enable |
| w_rd_addr | output | AW | Weight buffer address |
| w_rd_data | input | DW | Weight buffer data, one cycle after enable |
| o_rd_en | output | 1 | Output buffer read enable |
| o_rd_addr | output | AW | Output buffer read address |
| o_rd_data | input | SW | Output buffer read data, one cycle after enable |
| o_wr_en | output | 1 | Output buffer write enable |
| o_wr_addr | output | AW | Output buffer write address |
| o_wr_data | output | SW | Output buffer write data |
| done | output | 1 | One-cycle completion pulse |
| cnt_in_rd | output | CW | Input reads in the last run |
| cnt_w_rd | output | CW | Weight reads in the last run |
| cnt_o_rd | output | CW | Output reads in the last run |
| cnt_o_wr | output | CW | Output writes in the last run |

## Verification
The engine is driven with five patterns. A ramp with H=8 and R=3 exercises the mixed case, where early and late inputs reach fewer outputs than middle ones. R=1 makes every input write exactly one output, with no accumulation. R=H collapses the output to one entry that every tap hits. An alternating -128/127 pattern exposes sign-extension and signedness errors in the multiply-add. A long pseudo-random run with H=64 stresses the full index range and the upper-range guard. The output buffer is preloaded with a nonzero fill, so a missing first-tap zeroing or an out-of-range write is caught. One run is poked with a mid-run `start` to show that a busy engine ignores it.

// File: rtl/conv_is_pkg.sv
// Shared types for the input-stationary convolution engine.
package conv_is_pkg;

    // Sequencer states: fetch activation, capture it, walk taps, finish.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_LOAD  = 3'd2,
        ST_TAP   = 3'd3,
        ST_MAC   = 3'd4,
        ST_FIN   = 3'd5
    } seq_state_t;

    // Event slots in the access-counter bank.
    localparam int EV_IN_RD = 0;
    localparam int EV_W_RD  = 1;
    localparam int EV_O_RD  = 2;
    localparam int EV_O_WR  = 3;
    localparam int NUM_EV   = 4;

endpackage

// File: rtl/conv_is_idx.sv
// Target-index unit: forms e = h - r with one extra sign bit and flags
// whether e lies in the valid output range [0, H-R+1).
// Assumes r_lim <= h_lim, so the computed output length is at least one.
module conv_is_idx #(
    parameter int IW = 7
) (
    input  logic [IW-1:0] h_cur,
    input  logic [IW-1:0] r_cur,
    input  logic [IW-1:0] h_lim,
    input  logic [IW-1:0] r_lim,
    output logic          hit,
    output logic [IW-1:0] e_idx
);
    logic [IW:0] diff;
    logic [IW:0] e_lim;

    // Signed difference and output length, then the range gate.
    always_comb begin
        diff  = {1'b0, h_cur} - {1'b0, r_cur};
        e_lim = {1'b0, h_lim} - {1'b0, r_lim} + {{IW{1'b0}}, 1'b1};
        hit   = !diff[IW] && (diff < e_lim);
        e_idx = diff[IW-1:0];
    end
endmodule

// File: rtl/conv_is_seq.sv
// Loop sequencer: outer loop over input index h, inner loop over tap r.
// Per h: one input fetch, one capture cycle, then one cycle per tap, plus a
// second cycle for taps that hit a valid output (read, then write).
// Assumes the buffers return data one cycle after a read enable.
module conv_is_seq
    import conv_is_pkg::*;
#(
    parameter int IW = 7,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] cfg_h,
    input  logic [IW-1:0] cfg_r,
    input  logic          hit,
    input  logic [IW-1:0] e_idx,
    output logic [IW-1:0] h_cur,
    output logic [IW-1:0] r_cur,
    output logic [IW-1:0] h_lim,
    output logic [IW-1:0] r_lim,
    output logic          in_rd_en,
    output logic [AW-1:0] in_rd_addr,
    output logic          w_rd_en,
    output logic [AW-1:0] w_rd_addr,
    output logic          o_rd_en,
    output logic [AW-1:0] o_rd_addr,
    output logic          act_ld,
    output logic          mac_en,
    output logic          first_tap,
    output logic [AW-1:0] o_wr_addr,
    output logic          done,
    output logic          clr
);
    seq_state_t    state_q, state_d;
    logic [IW-1:0] h_q, h_d, r_q, r_d;
    logic [IW-1:0] hl_q, rl_q;
    logic          last_r, last_h, step;

    // Loop-end detection against the latched limits.
    always_comb begin
        last_r = (r_q == rl_q - {{(IW-1){1'b0}}, 1'b1});
        last_h = (h_q == hl_q - {{(IW-1){1'b0}}, 1'b1});
    end

    // Next-state and loop-counter update.
    always_comb begin
        state_d = state_q;
        h_d     = h_q;
        r_d     = r_q;
        step    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_FETCH;
                    h_d     = '0;
                    r_d     = '0;
                end
            end
            ST_FETCH: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_TAP;
            ST_TAP: begin
                if (hit) state_d = ST_MAC;
                else     step    = 1'b1;
            end
            ST_MAC:   step    = 1'b1;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (step) begin
            if (last_r) begin
                r_d = '0;
                if (last_h) begin
                    state_d = ST_FIN;
                end else begin
                    h_d     = h_q + {{(IW-1){1'b0}}, 1'b1};
                    state_d = ST_FETCH;
                end
            end else begin
                r_d     = r_q + {{(IW-1){1'b0}}, 1'b1};
                state_d = ST_TAP;
            end
        end
    end

    // State, loop indices and run limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            h_q     <= '0;
            r_q     <= '0;
            hl_q    <= '0;
            rl_q    <= '0;
        end else begin
            state_q <= state_d;
            h_q     <= h_d;
            r_q     <= r_d;
            if (state_q == ST_IDLE && start) begin
                hl_q <= cfg_h;
                rl_q <= cfg_r;
            end
        end
    end

    // Buffer strobes decoded from the current state.
    always_comb begin
        in_rd_en   = (state_q == ST_FETCH);
        in_rd_addr = h_q[AW-1:0];
        w_rd_en    = (state_q == ST_TAP) && hit;
        w_rd_addr  = r_q[AW-1:0];
        o_rd_en    = (state_q == ST_TAP) && hit;
        o_rd_addr  = e_idx[AW-1:0];
        act_ld     = (state_q == ST_LOAD);
        mac_en     = (state_q == ST_MAC);
        first_tap  = (r_q == '0);
        o_wr_addr  = e_idx[AW-1:0];
        done       = (state_q == ST_FIN);
        clr        = (state_q == ST_IDLE) && start;
        h_cur      = h_q;
        r_cur      = r_q;
        h_lim      = hl_q;
        r_lim      = rl_q;
    end
endmodule

// File: rtl/conv_is_mac.sv
// Multiply-add datapath: holds the stationary activation and forms
// old + act * weight, with old forced to zero on the first tap.
// Assumes SW >= 2*DW; the sum wraps at SW bits.
module conv_is_mac #(
    parameter int DW = 8,
    parameter int SW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_ld,
    input  logic signed [DW-1:0] in_data,
    input  logic                 first_tap,
    input  logic signed [DW-1:0] w_data,
    input  logic        [SW-1:0] o_data,
    output logic        [SW-1:0] sum
);
    localparam int PW = 2 * DW;

    logic signed [DW-1:0] act_q;
    logic signed [PW-1:0] prod;
    logic        [SW-1:0] prod_ext;
    logic        [SW-1:0] base;

    // Capture the stationary activation once per input index.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= '0;
        else if (act_ld) act_q <= in_data;
    end

    // Signed product, sign extension and accumulation.
    always_comb begin
        prod     = act_q * w_data;
        prod_ext = {{(SW-PW){prod[PW-1]}}, prod};
        base     = first_tap ? '0 : o_data;
        sum      = base + prod_ext;
    end
endmodule

// File: rtl/conv_is_cnt.sv
// Access-counter bank: one counter per event, cleared at run start.
// Assumes CW is wide enough for the largest run, so counters never wrap.
module conv_is_cnt #(
    parameter int NEV = 4,
    parameter int CW  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [NEV-1:0]    ev,
    output logic [NEV*CW-1:0] cnt_flat
);
    for (genvar g = 0; g < NEV; g++) begin : g_cnt
        logic [CW-1:0] c_q;

        // Count one event class.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) c_q <= '0;
            else if (ev[g])    c_q <= c_q + {{(CW-1){1'b0}}, 1'b1};
        end

        assign cnt_flat[g*CW +: CW] = c_q;
    end
endmodule

// File: rtl/conv_is_engine.sv
// Top: input-stationary valid 1-D convolution engine.
// Holds one activation, scatters its products over the filter taps into
// outputs h-r, and suppresses every pair that falls outside [0, H-R+1).
// Assumes 1 <= cfg_r <= cfg_h <= MAX_H, with both held stable during a run.
module conv_is_engine
    import conv_is_pkg::*;
#(
    parameter  int MAX_H = 64,
    parameter  int DW    = 8,
    parameter  int SW    = 24,
    localparam int IW    = $clog2(MAX_H + 1),
    localparam int AW    = $clog2(MAX_H),
    localparam int CW    = $clog2(MAX_H * MAX_H + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] cfg_h,
    input  logic [IW-1:0] cfg_r,
    output logic          in_rd_en,
    output logic [AW-1:0] in_rd_addr,
    input  logic [DW-1:0] in_rd_data,
    output logic          w_rd_en,
    output logic [AW-1:0] w_rd_addr,
    input  logic [DW-1:0] w_rd_data,
    output logic          o_rd_en,
    output logic [AW-1:0] o_rd_addr,
    input  logic [SW-1:0] o_rd_data,
    output logic          o_wr_en,
    output logic [AW-1:0] o_wr_addr,
    output logic [SW-1:0] o_wr_data,
    output logic          done,
    output logic [CW-1:0] cnt_in_rd,
    output logic [CW-1:0] cnt_w_rd,
    output logic [CW-1:0] cnt_o_rd,
    output logic [CW-1:0] cnt_o_wr
);
    logic [IW-1:0]        h_cur, r_cur, h_lim, r_lim, e_idx;
    logic                 hit, act_ld, mac_en, first_tap, clr;
    logic [NUM_EV-1:0]    ev;
    logic [NUM_EV*CW-1:0] cnt_flat;

    conv_is_idx #(.IW(IW)) u_idx (
        .h_cur (h_cur),
        .r_cur (r_cur),
        .h_lim (h_lim),
        .r_lim (r_lim),
        .hit   (hit),
        .e_idx (e_idx)
    );

    conv_is_seq #(.IW(IW), .AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_h      (cfg_h),
        .cfg_r      (cfg_r),
        .hit        (hit),
        .e_idx      (e_idx),
        .h_cur      (h_cur),
        .r_cur      (r_cur),
        .h_lim      (h_lim),
        .r_lim      (r_lim),
        .in_rd_en   (in_rd_en),
        .in_rd_addr (in_rd_addr),
        .w_rd_en    (w_rd_en),
        .w_rd_addr  (w_rd_addr),
        .o_rd_en    (o_rd_en),
        .o_rd_addr  (o_rd_addr),
        .act_ld     (act_ld),
        .mac_en     (mac_en),
        .first_tap  (first_tap),
        .o_wr_addr  (o_wr_addr),
        .done       (done),
        .clr        (clr)
    );

    conv_is_mac #(.DW(DW), .SW(SW)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_ld    (act_ld),
        .in_data   (in_rd_data),
        .first_tap (first_tap),
        .w_data    (w_rd_data),
        .o_data    (o_rd_data),
        .sum       (o_wr_data)
    );

    // Gather access events for the counter bank.
    always_comb begin
        o_wr_en          = mac_en;
        ev               = '0;
        ev[EV_IN_RD]     = in_rd_en;
        ev[EV_W_RD]      = w_rd_en;
        ev[EV_O_RD]      = o_rd_en;
        ev[EV_O_WR]      = mac_en;
    end

    conv_is_cnt #(.NEV(NUM_EV), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .ev       (ev),
        .cnt_flat (cnt_flat)
    );

    // Split the flat counter bus into the named outputs.
    always_comb begin
        cnt_in_rd = cnt_flat[EV_IN_RD*CW +: CW];
        cnt_w_rd  = cnt_flat[EV_W_RD*CW  +: CW];
        cnt_o_rd  = cnt_flat[EV_O_RD*CW  +: CW];
        cnt_o_wr  = cnt_flat[EV_O_WR*CW  +: CW];
    end
endmodule

// File: rtl/conv_is_engine_chk.sv
// Protocol checker for conv_is_engine, attached through bind.
// Assumes cfg_h and cfg_r stay stable while a run is in progress.
module conv_is_engine_chk #(
    parameter int IW = 7,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [IW-1:0] cfg_h,
    input logic [IW-1:0] cfg_r,
    input logic          in_rd_en,
    input logic          w_rd_en,
    input logic          o_rd_en,
    input logic [AW-1:0] o_rd_addr,
    input logic          o_wr_en,
    input logic [AW-1:0] o_wr_addr,
    input logic          done
);
    logic [IW:0] e_len;
    logic [IW:0] wr_ext;
    logic [IW:0] rd_ext;

    // Output length from the ports and zero-extended buffer addresses.
    always_comb begin
        e_len  = {1'b0, cfg_h} - {1'b0, cfg_r} + {{IW{1'b0}}, 1'b1};
        wr_ext = {{(IW+1-AW){1'b0}}, o_wr_addr};
        rd_ext = {{(IW+1-AW){1'b0}}, o_rd_addr};
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        o_wr_en |-> (wr_ext < e_len)); // R2
    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        o_rd_en |-> (rd_ext < e_len)); // R2
    AST_IN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd_en |=> !in_rd_en && !o_rd_en); // R3
    AST_W_WITH_O: assert property (@(posedge clk) disable iff (!rst_n)
        w_rd_en |-> o_rd_en); // R4
    AST_RMW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        o_wr_en |-> $past(o_rd_en) && ($past(o_rd_addr) == o_wr_addr)); // R5
    AST_NO_RD_IN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        o_wr_en |-> !o_rd_en); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(o_wr_en)); // R7
endmodule

bind conv_is_engine conv_is_engine_chk #(.IW(IW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_h     (cfg_h),
    .cfg_r     (cfg_r),
    .in_rd_en  (in_rd_en),
    .w_rd_en   (w_rd_en),
    .o_rd_en   (o_rd_en),
    .o_rd_addr (o_rd_addr),
    .o_wr_en   (o_wr_en),
    .o_wr_addr (o_wr_addr),
    .done      (done)
);

// File: tb/conv_is_engine_test.sv
// Scoreboard bench: the driver task predicts every output write in loop
// order and queues it; the monitor pops and compares each write as it occurs.
module conv_is_engine_test;
    localparam int MAX_H = 64;
    localparam int DW    = 8;
    localparam int SW    = 24;
    localparam int IW    = $clog2(MAX_H + 1);
    localparam int AW    = $clog2(MAX_H);
    localparam int CW    = $clog2(MAX_H * MAX_H + 1);
    localparam int LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW-1:0] cfg_h = '0;
    logic [IW-1:0] cfg_r = '0;
    logic          in_rd_en, w_rd_en, o_rd_en, o_wr_en, done;
    logic [AW-1:0] in_rd_addr, w_rd_addr, o_rd_addr, o_wr_addr;
    logic [DW-1:0] in_rd_data, w_rd_data;
    logic [SW-1:0] o_rd_data, o_wr_data;
    logic [CW-1:0] cnt_in_rd, cnt_w_rd, cnt_o_rd, cnt_o_wr;

    logic signed [DW-1:0] in_mem [MAX_H];
    logic signed [DW-1:0] w_mem  [MAX_H];
    logic        [SW-1:0] out_mem[MAX_H];
    logic        [SW-1:0] gold   [MAX_H];

    int            q_addr[$];
    logic [SW-1:0] q_data[$];
    int            exp_h = 0;
    int            checks = 0;
    int            errors = 0;
    int            pop_a;
    logic [SW-1:0] pop_d;

    always #10 clk = ~clk;

    conv_is_engine #(.MAX_H(MAX_H), .DW(DW), .SW(SW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_h      (cfg_h),
        .cfg_r      (cfg_r),
        .in_rd_en   (in_rd_en),
        .in_rd_addr (in_rd_addr),
        .in_rd_data (in_rd_data),
        .w_rd_en    (w_rd_en),
        .w_rd_addr  (w_rd_addr),
        .w_rd_data  (w_rd_data),
        .o_rd_en    (o_rd_en),
        .o_rd_addr  (o_rd_addr),
        .o_rd_data  (o_rd_data),
        .o_wr_en    (o_wr_en),
        .o_wr_addr  (o_wr_addr),
        .o_wr_data  (o_wr_data),
        .done       (done),
        .cnt_in_rd  (cnt_in_rd),
        .cnt_w_rd   (cnt_w_rd),
        .cnt_o_rd   (cnt_o_rd),
        .cnt_o_wr   (cnt_o_wr)
    );

    // Synchronous-read buffer models.
    always @(posedge clk) begin
        if (in_rd_en) in_rd_data <= in_mem[in_rd_addr];
        if (w_rd_en)  w_rd_data  <= w_mem[w_rd_addr];
        if (o_rd_en)  o_rd_data  <= out_mem[o_rd_addr];
        if (o_wr_en)  out_mem[o_wr_addr] <= o_wr_data;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compare each write with the scoreboard, and track input order.
    always @(negedge clk) begin
        if (rst_n) begin
            if (o_wr_en) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R1 unexpected write", longint'(o_wr_addr), -1);
                end else begin
                    pop_a = q_addr.pop_front();
                    pop_d = q_data.pop_front();
                    chk(int'(o_wr_addr) == pop_a, "R1 write address", longint'(o_wr_addr), longint'(pop_a));
                    chk(o_wr_data == pop_d, "R1/R6 write data", longint'(o_wr_data), longint'(pop_d));
                end
            end
            if (in_rd_en) begin
                chk(int'(in_rd_addr) == exp_h, "R3 input read order", longint'(in_rd_addr), longint'(exp_h));
                exp_h++;
            end
        end
    end

    // Driver: load buffers, predict writes, run, then check final state.
    task automatic run_case(input int hh, input int rr, input int seed, input bit alt, input bit poke);
        int ee;
        int cyc;
        bit ok;
        ee = hh - rr + 1;
        for (int i = 0; i < MAX_H; i++) begin
            if (alt) begin
                in_mem[i] = (i % 2 == 0) ? -8'sd128 : 8'sd127;
                w_mem[i]  = (i % 3 == 0) ? 8'sd127 : -8'sd128;
            end else begin
                in_mem[i] = DW'((i * 37 + seed * 11) % 256);
                w_mem[i]  = DW'((i * 53 + seed * 7 + 5) % 256);
            end
            out_mem[i] = 24'hA5A5A5 ^ SW'(i);
            gold[i]    = '0;
        end
        for (int h = 0; h < hh; h++) begin
            for (int r = 0; r < rr; r++) begin
                if (h - r >= 0 && h - r < ee) begin
                    gold[h-r] = ((r == 0) ? '0 : gold[h-r]) + SW'(int'(in_mem[h]) * int'(w_mem[r]));
                    q_addr.push_back(h - r);
                    q_data.push_back(gold[h-r]);
                end
            end
        end
        exp_h = 0;
        cfg_h = IW'(hh);
        cfg_r = IW'(rr);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (done !== 1'b1 && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            start = poke && (cyc == 10);   // R8: mid-run start must be ignored
        end
        start = 1'b0;
        chk(cyc < LIMIT, "watchdog", cyc, LIMIT);
        chk(q_addr.size() == 0, "R1 all writes seen", q_addr.size(), 0);
        chk(int'(cnt_in_rd) == hh, "R3/R9 input reads", cnt_in_rd, hh);
        chk(int'(cnt_w_rd) == ee * rr, "R4 weight reads", cnt_w_rd, ee * rr);
        chk(int'(cnt_o_rd) == ee * rr, "R4 output reads", cnt_o_rd, ee * rr);
        chk(int'(cnt_o_wr) == ee * rr, "R4 output writes", cnt_o_wr, ee * rr);
        ok = 1'b1;
        for (int e = 0; e < ee; e++) if (out_mem[e] != gold[e]) ok = 1'b0;
        chk(ok, "R1 final buffer", out_mem[0], gold[0]);
        ok = 1'b1;
        for (int e = ee; e < MAX_H; e++) if (out_mem[e] != (24'hA5A5A5 ^ SW'(e))) ok = 1'b0;
        chk(ok, "R2 entries above E untouched", ok, 1);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", done, 0);
        repeat (3) @(negedge clk);
        chk(int'(cnt_w_rd) == ee * rr, "R7 counters hold", cnt_w_rd, ee * rr);
        q_addr.delete();
        q_data.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!in_rd_en && !w_rd_en && !o_rd_en && !o_wr_en, "R9 enables low after reset",
            {in_rd_en, w_rd_en, o_rd_en, o_wr_en}, 0);
        chk(done == 1'b0, "R9 done low after reset", done, 0);
        chk(cnt_in_rd == '0 && cnt_w_rd == '0 && cnt_o_rd == '0 && cnt_o_wr == '0,
            "R9 counters zero after reset", cnt_w_rd, 0);
        run_case(8, 3, 1, 1'b0, 1'b1);    // mixed case, with mid-run start (R8)
        run_case(5, 1, 2, 1'b0, 1'b0);    // single tap, no accumulation
        run_case(6, 6, 3, 1'b0, 1'b0);    // one output, all taps (R6)
        run_case(20, 4, 4, 1'b1, 1'b0);   // signed extremes
        run_case(64, 7, 5, 1'b0, 1'b0);   // full range
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule